// File: doc/BRIEF.md
# Power-Down and Reset Sequencer

This block turns an external active-low power-down/reset pin into the internal power-down, reset and ready controls of a converter core. The pin may change at any time, so the block resynchronizes it into the master clock domain and only acts on it there. A low level lasting less than a set number of master clock periods is treated as a glitch and ignored. A low level that lasts long enough moves the block into the low-power state from wherever it is.

When the pin returns high, the block runs a short reset phase. During this phase the datapath clear strobe zeroes the serial port, filter and modulator state, and the control-load strobe restores the two control registers to their defaults. The block then holds ready low for a long, parameterized settling interval, measured in master clock cycles, while the clock recovery loop regains lock. Only after that interval does it assert ready. A separate power-on reset input initializes the sequencer's own flops. This input starts it in the low-power state.

Top module: `pwr_seq_top`

## Requirements
- R1: While `por_n` is low, the block is forced into the low-power state at once: `state_o`=0, `pwrdn_o`=1, and `ready_o`, `dp_clear_o` and `ctl_load_o` are all 0.
- R2: The pin passes through SYNC_STAGES (default 2) flops. From the low-power state, a pin set high before clock edge k shows `state_o`=1 (reset phase) after edge k+2.
- R3: A pin low level seen for fewer than MIN_LOW (default 4) consecutive synchronized samples has no effect on the state. This holds in every state, and the settling count keeps running.
- R4: A pin low level seen for MIN_LOW consecutive synchronized samples moves the block from any state to the low-power state one clock later. A low level of exactly MIN_LOW cycles is accepted.
- R5: The reset phase (`state_o`=1) lasts exactly RESET_CYCLES clocks. `dp_clear_o` and `ctl_load_o` are high in exactly those clocks, and the reset phase is only entered from the low-power state.
- R6: The settle phase (`state_o`=2) lasts exactly SETTLE_CYCLES clocks with `ready_o` low, and then `state_o` becomes 3.
- R7: `ready_o` is high only in the ready state (`state_o`=3). Once high, it stays high until a qualified low level or `por_n` arrives.
- R8: The state codes are 0 for low power, 1 for reset, 2 for settle and 3 for ready. At most one of `pwrdn_o`, `dp_clear_o` and `ready_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; must run for any qualification to happen |
| por_n | input | 1 | Active-low power-on reset of the sequencer flops (asynchronous) |
| pdrst_n | input | 1 | Asynchronous active-low power-down/reset pin |
| pwrdn_o | output | 1 | High in the low-power state |
| dp_clear_o | output | 1 | Datapath clear, high during the reset phase |
| ctl_load_o | output | 1 | Control register default load, high during the reset phase |
| ready_o | output | 1 | High once the settling interval has elapsed |
| state_o | output | 2 | Sequencer state code (see R8) |

## Verification
The assertions assume that the pin has already been resynchronized, so they reason about the synchronized level and the qualified-low event rather than the raw pin. They also assume that `por_n` is the only way the sequencer leaves its states outside the normal flow, which is why every property is disabled while it is low. The stimulus changes the pin only on the falling clock edge and holds each level for whole cycles. This lets the expected state after each hold be counted exactly through the synchronizer, qualifier and timers. The bench uses a short settle count so the full settle window, including its last cycle, is covered.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    ST_PD     = 2'd0,
    ST_RST    = 2'd1,
    ST_SETTLE = 2'd2,
    ST_READY  = 2'd3
  } seq_state_e;

  // Saturating step of a low-level run counter: restarts on a high sample.
  function automatic int unsigned low_run_step(input int unsigned cur,
                                               input logic        lvl,
                                               input int unsigned cap);
    if (lvl) return 0;
    if (cur >= cap) return cap;
    return cur + 1;
  endfunction

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pwr_seq_lowqual.sv
module pwr_seq_lowqual
  import pwr_seq_pkg::*;
#(
  parameter int MIN_LOW = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic lvl,
  output logic qual_low
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] CAP = CW'(MIN_LOW);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) run_q <= CAP;
    else        run_q <= CW'(low_run_step(int'(run_q), lvl, MIN_LOW));
  end

  assign qual_low = (run_q == CAP);
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic run,
  output logic done
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)   cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + 1'b1;
    else          cnt_q <= '0;
  end

  assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int MIN_LOW       = 4,
  parameter int RESET_CYCLES  = 3,
  parameter int SETTLE_CYCLES = 2700000
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       pdrst_n,
  output logic       pwrdn_o,
  output logic       dp_clear_o,
  output logic       ctl_load_o,
  output logic       ready_o,
  output logic [1:0] state_o
);
  // named internal events, observed by the bound checker
  logic pin_s;
  logic qual_low;
  logic rst_done;
  logic settle_done;

  seq_state_e st_q, st_d;

  pwr_seq_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .por_n(por_n), .d_async(pdrst_n), .q_sync(pin_s)
  );

  pwr_seq_lowqual #(.MIN_LOW(MIN_LOW)) qual_i (
    .clk(clk), .por_n(por_n), .lvl(pin_s), .qual_low(qual_low)
  );

  pwr_seq_timer #(.LIMIT(RESET_CYCLES)) rst_tmr_i (
    .clk(clk), .por_n(por_n), .run(st_q == ST_RST), .done(rst_done)
  );

  pwr_seq_timer #(.LIMIT(SETTLE_CYCLES)) settle_tmr_i (
    .clk(clk), .por_n(por_n), .run(st_q == ST_SETTLE), .done(settle_done)
  );

  always_comb begin
    st_d = st_q;
    if (st_q == ST_PD) begin
      if (pin_s) st_d = ST_RST;
    end else if (qual_low) begin
      st_d = ST_PD;
    end else begin
      unique case (st_q)
        ST_RST:    if (rst_done)    st_d = ST_SETTLE;
        ST_SETTLE: if (settle_done) st_d = ST_READY;
        default:   st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) st_q <= ST_PD;
    else        st_q <= st_d;
  end

  assign pwrdn_o    = (st_q == ST_PD);
  assign dp_clear_o = (st_q == ST_RST);
  assign ctl_load_o = (st_q == ST_RST);
  assign ready_o    = (st_q == ST_READY);
  assign state_o    = st_q;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int MIN_LOW       = 4,
  parameter int RESET_CYCLES  = 3,
  parameter int SETTLE_CYCLES = 16
) (
  input logic       clk,
  input logic       por_n,
  input logic       pin_s,
  input logic       qual_low,
  input logic       pwrdn_o,
  input logic       dp_clear_o,
  input logic       ctl_load_o,
  input logic       ready_o,
  input logic [1:0] state_o
);
  int unsigned low_run;
  int unsigned settle_run;
  int unsigned rst_run;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      low_run    <= MIN_LOW;
      settle_run <= 0;
      rst_run    <= 0;
    end else begin
      low_run    <= pin_s ? 0 : ((low_run >= MIN_LOW) ? MIN_LOW : low_run + 1);
      settle_run <= (state_o == 2'd2) ? settle_run + 1 : 0;
      rst_run    <= (state_o == 2'd1) ? rst_run + 1 : 0;
    end
  end

  p_enter_pd_r4: assert property (@(posedge clk) disable iff (!por_n)
    $rose(pwrdn_o) |-> $past(low_run) >= MIN_LOW);

  p_clear_from_pd_r5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(dp_clear_o) |-> $past(pwrdn_o));

  p_clear_len_r5: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(ctl_load_o) && (state_o == 2'd2)) |-> (rst_run == RESET_CYCLES));

  p_settle_len_r6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(ready_o) |-> (settle_run == SETTLE_CYCLES));

  p_ready_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
    (ready_o && !qual_low) |=> ready_o);

  p_excl_r8: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({pwrdn_o, dp_clear_o, ready_o}));
endmodule

bind pwr_seq_top pwr_seq_chk #(
  .MIN_LOW(MIN_LOW), .RESET_CYCLES(RESET_CYCLES), .SETTLE_CYCLES(SETTLE_CYCLES)
) chk_i (
  .clk(clk), .por_n(por_n), .pin_s(pin_s), .qual_low(qual_low),
  .pwrdn_o(pwrdn_o), .dp_clear_o(dp_clear_o), .ctl_load_o(ctl_load_o),
  .ready_o(ready_o), .state_o(state_o)
);

// File: tb/pwr_seq_top_tb_top.sv
`timescale 1ns/1ps
module pwr_seq_top_tb_top;
  localparam int MIN_LOW = 4;
  localparam int RST_N   = 3;
  localparam int SETTLE  = 20;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic pdrst_n = 1'b0;
  logic pwrdn_o, dp_clear_o, ctl_load_o, ready_o;
  logic [1:0] state_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pwr_seq_top #(
    .SYNC_STAGES(2), .MIN_LOW(MIN_LOW), .RESET_CYCLES(RST_N), .SETTLE_CYCLES(SETTLE)
  ) dut_i (
    .clk(clk), .por_n(por_n), .pdrst_n(pdrst_n), .pwrdn_o(pwrdn_o),
    .dp_clear_o(dp_clear_o), .ctl_load_o(ctl_load_o), .ready_o(ready_o),
    .state_o(state_o)
  );

  typedef struct packed {
    logic        pin;
    int unsigned hold;
    logic [1:0]  st;
    int unsigned req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 3,  2'd1, 2},  // R2 release seen three edges later
    '{1'b1, 3,  2'd2, 5},  // R5 reset phase of RST_N clocks then settle
    '{1'b1, 19, 2'd2, 6},  // R6 last settle cycle, ready still low
    '{1'b1, 1,  2'd3, 6},  // R6 ready after exactly SETTLE clocks
    '{1'b0, 3,  2'd3, 3},  // R3 short low pulse
    '{1'b1, 6,  2'd3, 3},  // R3 pulse of three ignored in ready
    '{1'b0, 4,  2'd3, 4},  // R4 low for exactly MIN_LOW
    '{1'b1, 3,  2'd0, 4},  // R4 accepted -> low power
    '{1'b1, 1,  2'd1, 2},  // R2 leave low power
    '{1'b1, 2,  2'd1, 5},  // R5 still in reset
    '{1'b1, 1,  2'd2, 5},  // R5 reset over
    '{1'b1, 8,  2'd2, 6},  // R6 mid settle
    '{1'b0, 6,  2'd2, 4},  // R4 low not yet qualified
    '{1'b0, 1,  2'd0, 4},  // R4 qualified low aborts settle
    '{1'b1, 3,  2'd1, 2},  // R2
    '{1'b1, 3,  2'd2, 5},  // R5
    '{1'b0, 3,  2'd2, 3},  // R3 short pulse during settle
    '{1'b1, 16, 2'd2, 3},  // R3 settle count not restarted
    '{1'b1, 1,  2'd3, 7},  // R7 ready on schedule
    '{1'b1, 10, 2'd3, 7}   // R7 ready held
  };

  task automatic check_state(input logic [1:0] exp, input int unsigned req);
    logic [4:0] act, want;
    act  = {state_o, pwrdn_o, dp_clear_o | ctl_load_o, ready_o};
    want = {exp, exp == 2'd0, exp == 2'd1, exp == 2'd3};
    total++;
    if (act !== want || dp_clear_o !== ctl_load_o) begin
      bad++;
      $display("FAIL R%0d state/outputs actual=%b clr=%b ld=%b expected=%b",
               req, act, dp_clear_o, ctl_load_o, want);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_state(2'd0, 1);  // R1 reset state while por_n low
    por_n = 1'b1;
    repeat (4) @(negedge clk);
    check_state(2'd0, 1);  // R1 stays low power with pin low

    for (int i = 0; i < NV; i++) begin
      pdrst_n = TBL[i].pin;
      repeat (TBL[i].hold) @(negedge clk);
      check_state(TBL[i].st, TBL[i].req);
    end

    // R1: power-on reset during ready acts at once
    #1 por_n = 1'b0;
    #1 check_state(2'd0, 1);
    @(negedge clk);
    por_n = 1'b1;
    // R8/R2: with pin high, the synchronizer restarts from low
    repeat (2) @(negedge clk);
    check_state(2'd0, 8);
    @(negedge clk);
    check_state(2'd1, 8);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule